// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Power-Up Initialization

This block keeps an asynchronous DRAM's contents alive and brings the device up after power-on. After reset it counts out a start-up delay. It then runs a burst of dummy refresh cycles, and only after that does it declare the memory usable. From then on an interval timer earns one refresh credit per period. The credits are stored in a small saturating debt counter, so the access controller can postpone refreshes and let the scheduler catch up later in a back-to-back burst.

Refresh cycles use one of two forms, picked per cycle by a mode input:
- **CAS-before-RAS.** The device generates the row internally.
- **RAS-only.** The block supplies the row from its own counter. The counter advances after every RAS-only cycle and wraps from the last row to row 0.

The scheduler shares the DRAM strobes with the access controller through a request/grant pair:
- `ref_req` goes high whenever a refresh is owed.
- A cycle starts only on a clock where `ref_req` and `ref_gnt` are both high and the scheduler is idle.
- Once started, the cycle runs to the end of its precharge regardless of `ref_gnt`. `ref_req` stays high for its whole length.
- The controller must route `ras_n`, `cas_n`, `we_n` and `row_addr` to the device while it grants.

All timing figures are counted in clock cycles and set by parameters. The defaults suit a 125 MHz clock:
- 25000-cycle start-up wait.
- 1950-cycle refresh interval.
- RAS low for 8 cycles, precharge for 5 cycles, CAS lead of 1 cycle.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, `ras_n`, `cas_n` and `we_n` are high, `ref_req` is low, `ready` is low and `row_addr` is 0.
- R2: `ref_req` stays low for the first INIT_CYC clock edges after reset is released and goes high after edge INIT_CYC.
- R3: `ready` stays low until INIT_REFS refresh cycles have completed after the start-up wait, rises in the cycle after the last one ends, and never falls again until reset. No interval credits are earned while `ready` is low.
- R4: A CAS-before-RAS cycle (`ras_only` = 0 at start) drives `cas_n` low for T_CSR cycles with `ras_n` high, then both low for T_RAS cycles, then both high for T_RP cycles. `we_n` is high at all times.
- R5: A RAS-only cycle (`ras_only` = 1 at start) keeps `cas_n` high, drives `ras_n` low for T_RAS cycles, then high for T_RP cycles. `row_addr` shows the row counter. The counter increments by one when a RAS-only cycle ends, wraps from 2^ROW_W-1 to 0, and is unchanged by CAS-before-RAS cycles.
- R6: A cycle starts only on an edge where the block is idle and `ref_req` and `ref_gnt` are both high. Its first strobe change appears after that edge. Once started, it completes even if `ref_gnt` falls, and `ref_req` stays high throughout.
- R7: Once `ready` is high, one refresh credit is earned every INTERVAL clock edges. `ref_req` is high whenever credits are owed, and each completed cycle consumes one credit.
- R8: The credit count saturates at DEBT_MAX. When the grant is withheld longer than DEBT_MAX intervals and then given, exactly DEBT_MAX cycles run back to back with one idle clock between them, plus any credit earned during the burst.
- R9: The refresh form is sampled only on the start edge. Changes on `ras_only` during a cycle do not alter that cycle's strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_only | input | 1 | 1 selects RAS-only refresh, 0 selects CAS-before-RAS |
| ref_gnt | input | 1 | Grant from the access controller |
| ref_req | output | 1 | Refresh request / bus hold |
| ready | output | 1 | Initialization complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| row_addr | output | ROW_W | Row address for RAS-only refresh |

## Verification
The bench runs the scheduler under four kinds of input pattern:
- **Permanent grant in CAS-before-RAS form.** Separates the start-up wait, the initialization burst and the steady one-per-interval rate.
- **Grant withheld for many intervals, then given.** Separates a saturating credit counter from an unbounded or lost one.
- **Grant dropped mid-cycle.** Shows whether a started cycle is cut short.
- **Mode flipped mid-cycle.** Shows whether the form is latched at the start.

A long run in RAS-only form covers a full pass of the row counter, so the wrap from the last row back to the first is observed.

A behavioural model built from counters and elapsed-cycle arithmetic predicts every output on every clock.

// File: rtl/dram_rfs_pkg.sv
package dram_rfs_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_LEAD  = 2'd1,
    SQ_ACT   = 2'd2,
    SQ_PRECH = 2'd3
  } seq_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rfs_init_ctrl.sv
module rfs_init_ctrl #(
  parameter int unsigned INIT_CYC  = 25000,
  parameter int unsigned INIT_REFS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_done,
  output logic wait_done,
  output logic init_pend,
  output logic ready
);
  localparam int unsigned WW = $clog2(INIT_CYC + 1);
  localparam int unsigned IW = $clog2(INIT_REFS + 1);

  logic [WW-1:0] wait_cnt;
  logic [IW-1:0] init_cnt;

  assign wait_done = (wait_cnt == WW'(INIT_CYC));
  assign ready     = (init_cnt == IW'(INIT_REFS));
  assign init_pend = wait_done && !ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
    end else if (!wait_done) begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_cnt <= '0;
    end else if (cyc_done && !ready) begin
      init_cnt <= init_cnt + 1'b1;
    end
  end

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready); // R3
  AST_NO_CYCLE_BEFORE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> wait_done); // R2

endmodule

// File: rtl/rfs_debt.sv
module rfs_debt #(
  parameter int unsigned INTERVAL = 1950,
  parameter int unsigned DEBT_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready,
  input  logic credit_used,
  output logic debt_pend
);
  localparam int unsigned TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int unsigned DW = $clog2(DEBT_MAX + 1);

  logic [TW-1:0] tmr;
  logic          tick;
  logic [DW-1:0] debt, debt_nx;

  assign tick      = ready && (tmr == TW'(INTERVAL - 1));
  assign debt_pend = (debt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr <= '0;
    end else if (ready) begin
      tmr <= tick ? '0 : tmr + 1'b1;
    end
  end

  always_comb begin
    debt_nx = debt;
    unique case ({tick, credit_used})
      2'b10: if (debt != DW'(DEBT_MAX)) debt_nx = debt + 1'b1;
      2'b01: if (debt != '0)            debt_nx = debt - 1'b1;
      default: debt_nx = debt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) debt <= '0;
    else        debt <= debt_nx;
  end

  AST_DEBT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    debt <= DW'(DEBT_MAX)); // R8
  AST_CREDIT_BACKED: assert property (@(posedge clk) disable iff (!rst_n)
    credit_used |-> debt_pend); // R7
  AST_NO_CREDIT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !debt_pend); // R3

endmodule

// File: rtl/rfs_seq.sv
module rfs_seq
  import dram_rfs_pkg::*;
#(
  parameter int unsigned T_CSR = 1,
  parameter int unsigned T_RAS = 8,
  parameter int unsigned T_RP  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic mode_ro,
  output logic busy,
  output logic done,
  output logic mode_q,
  output logic ras_n,
  output logic cas_n
);
  localparam int unsigned LMAX = max3(T_CSR, T_RAS, T_RP);
  localparam int unsigned CW   = $clog2(LMAX + 1);

  seq_state_e    st;
  logic [CW-1:0] cnt;
  logic          last;

  assign last  = (cnt == '0);
  assign busy  = (st != SQ_IDLE);
  assign done  = (st == SQ_PRECH) && last;
  assign ras_n = (st != SQ_ACT);
  assign cas_n = !((st == SQ_LEAD) || ((st == SQ_ACT) && !mode_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SQ_IDLE;
      cnt    <= '0;
      mode_q <= 1'b0;
    end else begin
      unique case (st)
        SQ_IDLE: if (start) begin
          mode_q <= mode_ro;
          if (mode_ro) begin
            st  <= SQ_ACT;
            cnt <= CW'(T_RAS - 1);
          end else begin
            st  <= SQ_LEAD;
            cnt <= CW'(T_CSR - 1);
          end
        end
        SQ_LEAD: if (last) begin
          st  <= SQ_ACT;
          cnt <= CW'(T_RAS - 1);
        end else cnt <= cnt - 1'b1;
        SQ_ACT: if (last) begin
          st  <= SQ_PRECH;
          cnt <= CW'(T_RP - 1);
        end else cnt <= cnt - 1'b1;
        SQ_PRECH: if (last) begin
          st <= SQ_IDLE;
        end else cnt <= cnt - 1'b1;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !mode_q) |-> (!cas_n && $past(!cas_n))); // R4
  AST_RO_CAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && mode_q) |-> cas_n); // R5
  AST_MODE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode_q)); // R9

endmodule

// File: rtl/rfs_row_ctr.sv
module rfs_row_ctr #(
  parameter int unsigned ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    row <= '0;
    else if (step) row <= row + 1'b1;
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int unsigned INIT_CYC  = 25000,
  parameter int unsigned INIT_REFS = 8,
  parameter int unsigned INTERVAL  = 1950,
  parameter int unsigned DEBT_MAX  = 8,
  parameter int unsigned ROW_W     = 10,
  parameter int unsigned T_CSR     = 1,
  parameter int unsigned T_RAS     = 8,
  parameter int unsigned T_RP      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_only,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             ready,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] row_addr
);
  logic wait_done, init_pend, debt_pend;
  logic busy, done, mode_q, pending, start;

  assign pending = ready ? debt_pend : init_pend;
  assign start   = !busy && pending && ref_gnt;
  assign ref_req = busy || pending;
  assign we_n    = 1'b1;

  rfs_init_ctrl #(.INIT_CYC(INIT_CYC), .INIT_REFS(INIT_REFS)) u_init (
    .clk(clk), .rst_n(rst_n), .cyc_done(done),
    .wait_done(wait_done), .init_pend(init_pend), .ready(ready));

  rfs_debt #(.INTERVAL(INTERVAL), .DEBT_MAX(DEBT_MAX)) u_debt (
    .clk(clk), .rst_n(rst_n), .ready(ready), .credit_used(done && ready),
    .debt_pend(debt_pend));

  rfs_seq #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_ro(ras_only),
    .busy(busy), .done(done), .mode_q(mode_q), .ras_n(ras_n), .cas_n(cas_n));

  rfs_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_n), .step(done && mode_q), .row(row_addr));

  AST_START_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> $past(ref_gnt)); // R6
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ref_req); // R6
  AST_ROW_ON_RO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (row_addr != $past(row_addr)) |-> $past(done && mode_q)); // R5
  AST_QUIET_DURING_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_done |-> !ref_req); // R2

endmodule

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
  localparam int INIT_CYC = 50, INIT_REFS = 8, INTERVAL = 100, DEBT_MAX = 8;
  localparam int ROW_W = 10, T_CSR = 1, T_RAS = 8, T_RP = 5;
  localparam int L_CBR = T_CSR + T_RAS + T_RP, L_RO = T_RAS + T_RP;
  localparam int NROWS = 1 << ROW_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, ras_only = 1'b0, ref_gnt = 1'b0;
  logic ref_req, ready, ras_n, cas_n, we_n;
  logic [ROW_W-1:0] row_addr;

  dram_refresh_sched #(.INIT_CYC(INIT_CYC), .INIT_REFS(INIT_REFS), .INTERVAL(INTERVAL),
    .DEBT_MAX(DEBT_MAX), .ROW_W(ROW_W), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) uut (
    .clk(clk), .rst_n(rst_n), .ras_only(ras_only), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ready(ready), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .row_addr(row_addr));

  int n_checks = 0, n_err = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  // Behavioural reference: elapsed edges, credits, remaining cycle length
  int m_edges, m_inits, m_since, m_debt, m_left, m_len, m_row;
  bit m_mode;
  logic m_ready, m_pend, m_busy, m_req, m_done, m_tick, e_ras, e_cas;
  int m_pos;
  assign m_ready = (m_inits >= INIT_REFS);
  assign m_busy  = (m_left > 0);
  assign m_pend  = m_ready ? (m_debt > 0) : (m_edges >= INIT_CYC);
  assign m_req   = m_busy || m_pend;
  assign m_done  = (m_left == 1);
  assign m_tick  = m_ready && ((m_since % INTERVAL) == INTERVAL - 1);
  assign m_pos   = m_len - m_left;
  assign e_ras = !(m_busy && (m_mode ? (m_pos < T_RAS)
                                     : (m_pos >= T_CSR && m_pos < T_CSR + T_RAS)));
  assign e_cas = !(m_busy && !m_mode && m_pos < T_CSR + T_RAS);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_edges <= 0; m_inits <= 0; m_since <= 0; m_debt <= 0;
      m_left <= 0; m_len <= 0; m_row <= 0; m_mode <= 0;
    end else begin
      if (m_edges < INIT_CYC) m_edges <= m_edges + 1;
      if (m_ready) m_since <= m_since + 1;
      if (!m_busy) begin
        if (m_req && ref_gnt) begin
          m_mode <= ras_only;
          m_len  <= ras_only ? L_RO : L_CBR;
          m_left <= ras_only ? L_RO : L_CBR;
        end
      end else m_left <= m_left - 1;
      if (m_done) begin
        if (!m_ready) m_inits <= m_inits + 1;
        if (m_mode) m_row <= (m_row + 1) % NROWS;
      end
      m_debt <= (m_debt + int'(m_tick) - int'(m_done && m_ready) > DEBT_MAX) ? DEBT_MAX
              : m_debt + int'(m_tick) - int'(m_done && m_ready);
    end
  end

  // Per-clock comparison and strobe monitor
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  int falls = 0, ro_falls = 0, last_ro_row = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(ref_req == m_req, "R6 ref_req", ref_req, m_req);
      chk(ready == m_ready, "R3 ready", ready, m_ready);
      chk(ras_n == e_ras, m_mode ? "R5 ras_n" : "R4 ras_n", ras_n, e_ras);
      chk(cas_n == e_cas, m_mode ? "R5 cas_n" : "R4 cas_n", cas_n, e_cas);
      chk(we_n == 1'b1, "R4 we_n", we_n, 1);
      chk(int'(row_addr) == m_row, "R5 row_addr", row_addr, m_row);
      if (prev_ras && !ras_n) begin
        falls++;
        if (!cas_n) chk(prev_cas == 1'b0, "R4 cas lead", prev_cas, 0);
        else begin
          ro_falls++;
          last_ro_row = row_addr;
        end
      end
    end
    prev_ras = ras_n;
    prev_cas = cas_n;
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int f0, r0, tgt;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes", {ras_n, cas_n, we_n}, 7);
    chk(!ref_req && !ready, "R1 req/ready", {ref_req, ready}, 0);
    chk(row_addr == '0, "R1 row", row_addr, 0);
    rst_n = 1'b1;
    ref_gnt = 1'b1;
    repeat (INIT_CYC - 1) @(negedge clk);
    chk(ref_req == 1'b0, "R2 before wait", ref_req, 0);
    @(negedge clk);
    chk(ref_req == 1'b1, "R2 after wait", ref_req, 1);
    for (int i = 0; i < 2000 && !ready; i++) @(negedge clk);
    chk(falls == INIT_REFS, "R3 init burst", falls, INIT_REFS);

    f0 = falls;
    repeat (10 * INTERVAL) @(negedge clk);
    chk(falls - f0 >= 9 && falls - f0 <= 11, "R7 rate", falls - f0, 10);

    ras_only = 1'b1;
    for (int i = 0; i < 500 && !(ras_n == 1'b0 && cas_n == 1'b1); i++) @(negedge clk);
    ras_only = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(cas_n == 1'b1, "R9 mode held", cas_n, 1);
    end

    for (int i = 0; i < 500 && ref_req; i++) @(negedge clk);
    ref_gnt = 1'b0;
    repeat (12 * INTERVAL) @(negedge clk);
    chk(ref_req == 1'b1, "R8 debt owed", ref_req, 1);
    f0 = falls;
    ref_gnt = 1'b1;
    for (int i = 0; i < 2000 && ref_req; i++) @(negedge clk);
    chk(falls - f0 >= DEBT_MAX && falls - f0 <= DEBT_MAX + 2, "R8 burst",
        falls - f0, DEBT_MAX);

    for (int i = 0; i < 500 && ras_n; i++) @(negedge clk);
    ref_gnt = 1'b0;
    for (int i = 0; i < T_RAS + 2 && !ras_n; i++) @(negedge clk);
    chk(ras_n == 1'b1 && ref_req == 1'b1, "R6 cycle completes", {ras_n, ref_req}, 3);
    ref_gnt = 1'b1;

    ras_only = 1'b1;
    tgt = ro_falls + 1;
    while (ro_falls < tgt) @(negedge clk);
    r0 = last_ro_row;
    tgt = ro_falls + NROWS;
    while (ro_falls < tgt) @(negedge clk);
    chk(last_ro_row == r0, "R5 row wrap", last_ro_row, r0);
    repeat (5) @(negedge clk);
    summary();
  end

endmodule